// File: doc/BRIEF.md
# Positional Interrupt Acknowledge Chain

This block collects interrupt requests from a parameterised number of device slots onto one shared request line and settles, through an acknowledge that ripples from slot to slot, which of them gets served. Each slot keeps a pending flag, which a one-cycle raise pulse sets, and a fixed identifier. The shared request output is the OR of every pending flag. No central encoder picks the winner. The ripple order alone decides it: the acknowledge enters slot 0 and moves on only through slots that are idle.

During a clock cycle with the acknowledge input high, the first pending slot in ripple order stops the acknowledge. That slot places its identifier on the shared data bus, and the processor latches that value as the interrupt cause. On the clock edge that ends the acknowledge cycle, the winning slot drops its pending flag. If no slot is pending, the bus reads zero and the chain-out signal goes high, which tells the processor that nobody claimed the acknowledge. Every pin is plain control or status. There is no streamed data, so no valid/ready handshake is used, and back-pressure does not apply.

Top module: `irq_ack_chain`

## Requirements
- R1: Out of reset, every pending flag is clear and `irq_req` is low.
- R2: `irq_req` is high during exactly the cycles in which at least one pending flag is set. A raise pulse on slot k sets that slot's flag at the next clock edge.
- R3: A slot whose flag is clear passes the acknowledge on to the next slot unchanged.
- R4: The acknowledge stops at the lowest-numbered pending slot, so slot 0 has the highest priority.
- R5: During an acknowledge cycle, `ack_bus` carries the identifier of the winning slot. The identifier of slot k is k+1, in ID_W bits, so zero is never a valid identifier.
- R6: At most one slot drives the bus in any cycle. Outside acknowledge cycles `ack_bus` is zero.
- R7: The winning slot's flag clears at the edge that ends the acknowledge cycle, and no other slot's flag changes. If a raise arrives on the winning slot in that same cycle, the flag stays set, and the new request is served in a later round.
- R8: When an acknowledge arrives and no slot is pending, `ack_bus` is zero and `ack_unclaimed` is high. `ack_unclaimed` is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raise | input | N | One bit per slot. A high bit sets that slot's pending flag. |
| ack_in | input | 1 | Acknowledge from the processor, high for one cycle per round |
| irq_req | output | 1 | Shared request line, the OR of all pending flags |
| ack_bus | output | ID_W | Identifier of the slot that claimed the acknowledge, zero otherwise |
| ack_unclaimed | output | 1 | The acknowledge passed through every slot without being claimed |
| pend_vec | output | N | Pending flag of each slot |

## Verification
The bench goes after these corner cases:
- Several slots pending at once. A chain that picks the wrong slot puts the wrong identifier on the bus and clears the wrong flag.
- A raise that lands on the winning slot in the same cycle as its acknowledge. A design that lets the clear win would silently drop that second request.
- An acknowledge with nothing pending. A wrong design would leave stale data on the bus or fail to raise `ack_unclaimed`.
- Slots that are high in priority but idle. If they absorb the acknowledge anyway, lower-priority slots are never served. The bench drains full request sets one round at a time to expose this.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
  typedef enum logic [1:0] {
    SL_IDLE  = 2'd0,
    SL_PASS  = 2'd1,
    SL_CLAIM = 2'd2
  } slot_act_e;
endpackage

// File: rtl/irq_chain_slot.sv
module irq_chain_slot #(
  parameter int ID_W = 8,
  parameter int SLOT_ID = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            raise,
  input  logic            ack_prev,
  output logic            ack_next,
  output logic            pending,
  output logic [ID_W-1:0] bus_part,
  output logic            claim
);
  import irq_chain_pkg::*;
  slot_act_e act;
  logic pend_q;

  always_comb begin
    if (!ack_prev) act = SL_IDLE;
    else if (pend_q) act = SL_CLAIM;
    else act = SL_PASS;
  end

  assign claim    = (act == SL_CLAIM);
  assign ack_next = (act == SL_PASS);
  assign bus_part = claim ? ID_W'(SLOT_ID) : '0;
  assign pending  = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= 1'b0;
    else if (raise) pend_q <= 1'b1;
    else if (claim) pend_q <= 1'b0;
  end

  // R3: an idle slot hands the acknowledge on
  p_pass_through_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_prev && !pend_q) |-> ack_next);
  // R7: claim without a new raise clears the flag
  p_claim_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (claim && !raise) |=> !pending);
  // R7: claim with a raise in the same cycle keeps the flag set
  p_claim_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (claim && raise) |=> pending);
endmodule

// File: rtl/irq_chain_combine.sv
module irq_chain_combine #(
  parameter int N = 4,
  parameter int ID_W = 8
) (
  input  logic [N-1:0]           claims,
  input  logic [N-1:0][ID_W-1:0] parts,
  output logic [ID_W-1:0]        bus
);
  always_comb begin
    bus = '0;
    for (int i = 0; i < N; i++) bus = bus | parts[i];
  end

  // R6: at most one slot drives the bus
  always_comb p_one_driver_r6: assert ($onehot0(claims));
endmodule

// File: rtl/irq_ack_chain.sv
module irq_ack_chain #(
  parameter int N = 4,
  parameter int ID_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    raise,
  input  logic            ack_in,
  output logic            irq_req,
  output logic [ID_W-1:0] ack_bus,
  output logic            ack_unclaimed,
  output logic [N-1:0]    pend_vec
);
  logic [N:0]                ack_rip;
  logic [N-1:0]              claims;
  logic [N-1:0][ID_W-1:0]    parts;

  assign ack_rip[0] = ack_in;

  for (genvar g = 0; g < N; g++) begin : g_slot
    irq_chain_slot #(.ID_W(ID_W), .SLOT_ID(g + 1)) u_slot (
      .clk(clk), .rst_n(rst_n), .raise(raise[g]),
      .ack_prev(ack_rip[g]), .ack_next(ack_rip[g+1]),
      .pending(pend_vec[g]), .bus_part(parts[g]), .claim(claims[g])
    );
  end

  irq_chain_combine #(.N(N), .ID_W(ID_W)) u_comb (
    .claims(claims), .parts(parts), .bus(ack_bus)
  );

  assign irq_req       = |pend_vec;
  assign ack_unclaimed = ack_rip[N];

  // R2: a raise is visible on the request line next cycle
  p_raise_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|raise) |=> irq_req);
  // R8: an acknowledge with nothing pending leaves the bus at zero
  p_unclaimed_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_unclaimed |-> (ack_bus == '0 && pend_vec == '0));
  // R5: a claimed acknowledge never shows zero on the bus
  p_bus_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_in && irq_req) |-> (ack_bus != '0));
  // R6: bus idle outside acknowledges
  p_bus_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_in |-> (ack_bus == '0));
endmodule

// File: tb/irq_ack_chain_bench.sv
module irq_ack_chain_bench;
  localparam int N = 4;
  localparam int ID_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] raise = '0;
  logic ack_in = 1'b0;
  logic irq_req, ack_unclaimed;
  logic [ID_W-1:0] ack_bus;
  logic [N-1:0] pend_vec;

  int compared = 0;
  int mismatched = 0;
  bit model_pend [N];
  int cyc = 0;

  always #4 clk = ~clk;

  irq_ack_chain #(.N(N), .ID_W(ID_W)) u_irq_ack_chain (
    .clk(clk), .rst_n(rst_n), .raise(raise), .ack_in(ack_in),
    .irq_req(irq_req), .ack_bus(ack_bus),
    .ack_unclaimed(ack_unclaimed), .pend_vec(pend_vec)
  );

  task automatic chk(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  // behavioural reference, compared at the negative edge of every cycle
  always @(negedge clk) begin
    if (rst_n) begin
      int win;
      int anyp;
      win = -1;
      anyp = 0;
      for (int i = 0; i < N; i++) begin
        if (model_pend[i]) anyp = 1;
        if (model_pend[i] && win < 0) win = i;
      end
      chk("R2 irq_req", irq_req, anyp);
      for (int i = 0; i < N; i++) chk("R7 pend_vec", pend_vec[i], model_pend[i]);
      if (ack_in) begin
        chk("R4/R5 ack_bus", ack_bus, (win < 0) ? 0 : win + 1);
        chk("R8 ack_unclaimed", ack_unclaimed, (win < 0) ? 1 : 0);
      end else begin
        chk("R6 ack_bus idle", ack_bus, 0);
        chk("R8 ack_unclaimed idle", ack_unclaimed, 0);
      end
    end
  end

  // model state update at the rising edge
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      for (int i = 0; i < N; i++) model_pend[i] = 1'b0;
    end else begin
      int win;
      win = -1;
      for (int i = 0; i < N; i++) if (model_pend[i] && win < 0) win = i;
      if (ack_in && win >= 0) model_pend[win] = 1'b0;
      for (int i = 0; i < N; i++) if (raise[i]) model_pend[i] = 1'b1;
    end
  end

  task automatic step(logic [N-1:0] r, logic a);
    @(negedge clk);
    #1;
    raise = r;
    ack_in = a;
  endtask

  initial begin : watchdog
    #1000000;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 irq_req", irq_req, 0);
    chk("R1 pend_vec", pend_vec, 0);
    #1 rst_n = 1'b1;
    // R8 ack with nothing pending
    step('0, 1'b1);
    step('0, 1'b0);
    // R2 single raise, R3 passes slots 0..1, R4/R5 winner slot 2
    step(4'b0100, 1'b0);
    step('0, 1'b0);
    step('0, 1'b1);
    step('0, 1'b0);
    // R4 all pending, drain in order
    step(4'b1111, 1'b0);
    for (int k = 0; k < N; k++) begin
      step('0, 1'b1);
      step('0, 1'b0);
    end
    step('0, 1'b1);
    // R7 raise on winner during its acknowledge keeps it
    step(4'b0010, 1'b0);
    step(4'b0010, 1'b1);
    step('0, 1'b0);
    step('0, 1'b1);
    // R7 raise on other slot during ack, back-to-back acks
    step(4'b1001, 1'b0);
    step(4'b0100, 1'b1);
    step('0, 1'b1);
    step('0, 1'b1);
    step('0, 1'b1);
    step('0, 1'b0);
    // pattern sweep
    for (int p = 0; p < 16; p++) begin
      step(4'(p), 1'b0);
      step('0, 1'b1);
      step('0, 1'b1);
    end
    step('0, 1'b0);
    step('0, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule